// File: doc/BRIEF.md
# Zero-Wait Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Reads and writes can follow each other on consecutive clocks without idle cycles. Each word holds 36 bits in four 9-bit byte lanes, and the depth is set by the address width parameter. All inputs are sampled on the rising clock edge. One strobe chooses between two actions: starting a new operation at an external address, or advancing a 2-bit burst counter inside the current operation.

A read presents its data combinationally in the clock cycle after its address is registered, and a valid flag marks that data. A write takes its data and byte enables one clock after its address. The write then waits one cycle in a pending register before it reaches the array. A read that arrives during that cycle gets the pending bytes through a bypass path, so a write followed at once by a read of the same location returns the new data. An active-high clock-enable-bar input freezes the whole block.

Top module: `zbtSram`

## Requirements
- R1: After reset the block is deselected, so `rdValid` is 0 and `rdData` is all zeros.
- R2: When `advLdN`=0 on an enabled edge and all three chip selects are active (`ce0N`=0, `ce1`=1, `ce2N`=0), a read (`rdWrN`=1) to address A drives `rdValid`=1 and the word at A on `rdData` during the following cycle.
- R3: For a write started (`rdWrN`=0) at address A, `wrData` and `byteEnN` are sampled on the next enabled edge, and a later read of A returns that data.
- R4: Byte lane i covers bits [9i+8:9i]. A write changes lane i only when `byteEnN[i]`=0, and other lanes keep their old contents.
- R5: With `burstMode`=0 sampled at the load, each edge with `advLdN`=1 advances the burst. Address bits [1:0] become (start + count) mod 4, and the upper bits do not change.
- R6: With `burstMode`=1 sampled at the load, address bits [1:0] become start XOR count. Changes on `burstMode` during the burst have no effect.
- R7: A load with any chip select inactive is a deselect. `rdValid` is 0 during it, and write data supplied afterwards changes no memory word.
- R8: Advances issued while deselected leave the block deselected, even when the chip selects are active.
- R9: While `clkEnN`=1, every input is ignored and all state holds. `rdValid` and `rdData` keep their values, and write data is not captured.
- R10: A write to A whose data cycle carries a load that reads A returns the new data in the next cycle, with no idle cycle between them.
- R11: `rdValid` is 0 during every cycle of a write operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Active-low clock enable; 1 suspends the block |
| advLdN | input | 1 | 0 loads a new operation, 1 advances the burst |
| rdWrN | input | 1 | 1 for read, 0 for write, sampled at a load |
| byteEnN | input | 4 | Active-low lane write enables, sampled with write data |
| ce0N | input | 1 | Chip select, active low |
| ce1 | input | 1 | Chip select, active high |
| ce2N | input | 1 | Chip select, active low |
| burstMode | input | 1 | 1 interleaved order, 0 linear order, sampled at a load |
| addr | input | ADDR_W | Word address |
| wrData | input | 36 | Write data |
| rdData | output | 36 | Flow-through read data, zero when not valid |
| rdValid | output | 1 | High while a selected read drives `rdData` |

## Verification
A wrong burst step or a wrong latched mode shows up as a word out of order on `rdData` in the very cycle of the bad beat. The prefilled words are all distinct, so the first bad beat of a burst identifies itself. A lost or early pending write shows up on the next read of that address, and through the bypass that read can be the very next cycle. A stuck select or operation flag shows in `rdValid` one cycle after the load that should have changed it. Suspend is tested by holding `clkEnN` high across load and data edges and checking that the outputs do not move.

// File: rtl/zbtSramPkg.sv
package zbtSramPkg;

  typedef struct packed {
    logic en;        // clock edge is enabled
    logic rdActive;  // a selected read owns the current cycle
    logic wrCapture; // this edge samples data for the current write beat
  } zbtStrobeT;

  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic interleave);
    return interleave ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/zbtSramCtrl.sv
module zbtSramCtrl
  import zbtSramPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              advLdN,
  input  logic              rdWrN,
  input  logic              ce0N,
  input  logic              ce1,
  input  logic              ce2N,
  input  logic              burstMode,
  input  logic [ADDR_W-1:0] addr,
  output zbtStrobeT         strobes,
  output logic [ADDR_W-1:0] opAddr
);

  localparam int UP_W = ADDR_W - 2;

  logic              activeQ;
  logic              isWriteQ;
  logic              modeQ;
  logic [ADDR_W-1:0] baseQ;
  logic [1:0]        cntQ;
  logic              allSel;

  assign allSel = !ce0N && ce1 && !ce2N;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      isWriteQ <= 1'b0;
      modeQ    <= 1'b0;
      baseQ    <= '0;
      cntQ     <= '0;
    end else if (!clkEnN) begin
      if (!advLdN) begin
        activeQ  <= allSel;
        isWriteQ <= !rdWrN;
        modeQ    <= burstMode;
        baseQ    <= addr;
        cntQ     <= '0;
      end else if (activeQ) begin
        cntQ <= cntQ + 2'd1;
      end
    end
  end

  assign opAddr = {baseQ[ADDR_W-1:2], burstLow(baseQ[1:0], cntQ, modeQ)};

  always_comb begin
    strobes.en        = !clkEnN;
    strobes.rdActive  = activeQ && !isWriteQ;
    strobes.wrCapture = activeQ && isWriteQ && !clkEnN;
  end

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(activeQ) && $stable(opAddr))); // R9
  AST_DESEL_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && advLdN && !activeQ) |=> !activeQ); // R8
  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && advLdN && activeQ) |=>
      ($stable(opAddr[ADDR_W-1:2]) && (opAddr[1:0] != $past(opAddr[1:0])))); // R5
  AST_LOAD_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLdN && ce0N) |=> (!strobes.rdActive && !activeQ)); // R7

  logic unusedUp;
  assign unusedUp = ^UP_W;

endmodule

// File: rtl/zbtSramDatapath.sv
module zbtSramDatapath
  import zbtSramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  zbtStrobeT               strobes,
  input  logic [ADDR_W-1:0]       opAddr,
  input  logic [LANES-1:0]        byteEnN,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] memQ [DEPTH];
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [WORD_W-1:0] pendData;
  logic [LANES-1:0]  pendBe;

  always_ff @(posedge clk) begin
    if (strobes.en && pendValid) begin
      for (int i = 0; i < LANES; i++) begin
        if (pendBe[i]) memQ[pendAddr][i*LANE_W +: LANE_W] <= pendData[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
      pendBe    <= '0;
    end else if (strobes.en) begin
      pendValid <= strobes.wrCapture;
      if (strobes.wrCapture) begin
        pendAddr <= opAddr;
        pendData <= wrData;
        pendBe   <= ~byteEnN;
      end
    end
  end

  logic              hit;
  logic [WORD_W-1:0] memWord;
  logic [WORD_W-1:0] merged;

  assign hit     = pendValid && (pendAddr == opAddr);
  assign memWord = memQ[opAddr];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign merged[g*LANE_W +: LANE_W] = (hit && pendBe[g]) ? pendData[g*LANE_W +: LANE_W]
                                                          : memWord[g*LANE_W +: LANE_W];
  end

  assign rdValid = strobes.rdActive;
  assign rdData  = rdValid ? merged : '0;

  AST_PEND_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.en && pendValid && !strobes.wrCapture) |=> !pendValid); // R3
  AST_SUSPEND_PEND: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.en |=> ($stable(pendValid) && $stable(pendAddr) && $stable(pendData))); // R9

endmodule

// File: rtl/zbtSram.sv
module zbtSram
  import zbtSramPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              advLdN,
  input  logic              rdWrN,
  input  logic [3:0]        byteEnN,
  input  logic              ce0N,
  input  logic              ce1,
  input  logic              ce2N,
  input  logic              burstMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [35:0]       wrData,
  output logic [35:0]       rdData,
  output logic              rdValid
);

  zbtStrobeT         strobes;
  logic [ADDR_W-1:0] opAddr;

  zbtSramCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advLdN(advLdN), .rdWrN(rdWrN),
    .ce0N(ce0N), .ce1(ce1), .ce2N(ce2N), .burstMode(burstMode), .addr(addr),
    .strobes(strobes), .opAddr(opAddr)
  );

  zbtSramDatapath #(.ADDR_W(ADDR_W), .LANES(4), .LANE_W(9)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opAddr(opAddr),
    .byteEnN(byteEnN), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/zbtSram_bench.sv
module zbtSram_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEnN = 1'b0, advLdN = 1'b0, rdWrN = 1'b1;
  logic [3:0]  byteEnN = 4'hF;
  logic        ce0N = 1'b1, ce1 = 1'b1, ce2N = 1'b0, burstMode = 1'b0;
  logic [7:0]  addr = '0;
  logic [35:0] wrData = '0;
  logic [35:0] rdData;
  logic        rdValid;

  logic [35:0] expMem [256];
  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  zbtSram #(.ADDR_W(8)) u_zbtSram (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advLdN(advLdN), .rdWrN(rdWrN),
    .byteEnN(byteEnN), .ce0N(ce0N), .ce1(ce1), .ce2N(ce2N), .burstMode(burstMode),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] beN);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (!beN[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic drvLoad(bit wr, logic [7:0] a, bit mode);
    advLdN = 0; rdWrN = !wr; addr = a; burstMode = mode;
    ce0N = 0; ce1 = 1; ce2N = 0;
  endtask

  task automatic drvDesel();
    advLdN = 0; ce0N = 1; ce1 = 1; ce2N = 0;
  endtask

  task automatic writeWord(logic [7:0] a, logic [35:0] d, logic [3:0] beN);
    drvLoad(1, a, 0);
    step();
    wrData = d; byteEnN = beN; drvDesel();
    expMem[a] = merge(expMem[a], d, beN);
    step();
  endtask

  task automatic readCheck(string req, logic [7:0] a);
    drvLoad(0, a, 0);
    step();
    check(req, {35'b0, rdValid}, 36'd1);
    check(req, rdData, expMem[a]);
    drvDesel();
    step();
  endtask

  task automatic tReset();
    check("R1 valid", {35'b0, rdValid}, 36'd0);
    check("R1 data", rdData, 36'd0);
  endtask

  task automatic tSingle();
    writeWord(8'd5, 36'h1_2345_6789, 4'h0);
    readCheck("R2/R3 single", 8'd5);
  endtask

  task automatic tByteEn();
    writeWord(8'd9, 36'hA_AAAA_AAAA, 4'h0);
    writeWord(8'd9, 36'h5_5555_5555, 4'b1010);
    readCheck("R4 lanes", 8'd9);
  endtask

  task automatic tBackToBack();
    writeWord(8'd21, 36'h0_0000_0021, 4'h0);
    drvLoad(1, 8'd20, 0);
    step();
    check("R11 write cycle", {35'b0, rdValid}, 36'd0);
    wrData = 36'hC_0FFE_E020; byteEnN = 4'h0; drvLoad(0, 8'd20, 0);
    expMem[20] = 36'hC_0FFE_E020;
    step();
    check("R10 bypass valid", {35'b0, rdValid}, 36'd1);
    check("R10 bypass data", rdData, expMem[20]);
    drvLoad(1, 8'd21, 0);
    step();
    check("R11 write after read", {35'b0, rdValid}, 36'd0);
    wrData = 36'h9_8765_4321; byteEnN = 4'b0011; drvLoad(0, 8'd21, 0);
    expMem[21] = merge(expMem[21], 36'h9_8765_4321, 4'b0011);
    step();
    check("R10 partial bypass", rdData, expMem[21]);
    drvDesel();
    step();
  endtask

  task automatic tBurst(string req, bit mode, logic [1:0] s, logic [7:0] base);
    drvLoad(1, base + 8'(s), mode);
    step();
    for (int k = 0; k < 4; k++) begin
      logic [1:0] lo = mode ? (s ^ 2'(k)) : (s + 2'(k));
      logic [7:0] a = {base[7:2], lo};
      check({req, " write beat"}, {35'b0, rdValid}, 36'd0);
      wrData = {4'(k), 24'hB0B0B0, base} ^ 36'(k * 7 + 1); byteEnN = 4'h0;
      expMem[a] = wrData;
      if (k < 3) begin
        advLdN = 1;
        if (k == 1) burstMode = !mode;
      end else drvDesel();
      step();
    end
    drvLoad(0, base + 8'(s), mode);
    step();
    for (int k = 0; k < 4; k++) begin
      logic [1:0] lo = mode ? (s ^ 2'(k)) : (s + 2'(k));
      check({req, " read beat"}, rdData, expMem[{base[7:2], lo}]);
      if (k < 3) begin
        advLdN = 1;
        if (k == 0) burstMode = !mode;
      end else drvDesel();
      step();
    end
  endtask

  task automatic tDeselect();
    writeWord(8'd50, 36'h3_3333_3333, 4'h0);
    for (int c = 0; c < 3; c++) begin
      drvLoad(1, 8'd50, 0);
      if (c == 0) ce0N = 1; else if (c == 1) ce1 = 0; else ce2N = 1;
      step();
      check("R7 desel valid", {35'b0, rdValid}, 36'd0);
      wrData = 36'hF_FFFF_FFFF; byteEnN = 4'h0; drvDesel();
      step();
      drvLoad(0, 8'd50, 0);
      if (c == 0) ce0N = 1; else if (c == 1) ce1 = 0; else ce2N = 1;
      step();
      check("R7 desel read", {35'b0, rdValid}, 36'd0);
    end
    readCheck("R7 untouched", 8'd50);
  endtask

  task automatic tDeselAdvance();
    drvDesel();
    step();
    ce0N = 0; ce1 = 1; ce2N = 0; advLdN = 1; rdWrN = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R8 advance deselected", {35'b0, rdValid}, 36'd0);
    end
    drvDesel();
    step();
  endtask

  task automatic tSuspend();
    writeWord(8'd60, 36'h6_0606_0606, 4'h0);
    drvLoad(0, 8'd60, 0);
    step();
    check("R9 pre", rdData, expMem[60]);
    clkEnN = 1; drvLoad(1, 8'd61, 0);
    step();
    step();
    check("R9 hold valid", {35'b0, rdValid}, 36'd1);
    check("R9 hold data", rdData, expMem[60]);
    clkEnN = 0; drvLoad(1, 8'd62, 0);
    step();
    clkEnN = 1; wrData = 36'h0_DEAD_0000; byteEnN = 4'h0; drvLoad(0, 8'd62, 0);
    step();
    check("R9 suspended write", {35'b0, rdValid}, 36'd0);
    clkEnN = 0; wrData = 36'h6_2626_2626; drvDesel();
    expMem[62] = 36'h6_2626_2626;
    step();
    readCheck("R9 data after resume", 8'd62);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) expMem[i] = '0;
    step();
    step();
    tReset();
    rstN = 1;
    drvDesel();
    step();
    tReset();
    tSingle();
    tByteEn();
    tBackToBack();
    tBurst("R5 linear", 1'b0, 2'd1, 8'd32);
    tBurst("R5 linear wrap", 1'b0, 2'd3, 8'd36);
    tBurst("R6 interleaved", 1'b1, 2'd1, 8'd40);
    tBurst("R6 interleaved s2", 1'b1, 2'd2, 8'd44);
    tDeselect();
    tDeselAdvance();
    tSuspend();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nVec++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule